// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Threshold Flags

This block is a 9-bit-wide first-in first-out buffer. It has a write clock and a read clock that are independent of each other. The write side reports full and nearly-full conditions, and the read side reports empty and nearly-empty conditions. All four flags are active low. Each pointer crosses into the other clock domain as a Gray code through a two-stage synchronizer. The pointers carry one extra bit, so that a full buffer can be told apart from an empty one.

The two "nearly" thresholds are held in two 18-bit offset registers. Software loads them nine bits at a time through the data input, and reads them back nine bits at a time through the data output. The dual-role pin `wen2_ld` decides how this works. Its level while reset is held is latched separately in each clock domain.

- If the pin is held high during reset, it acts as a second, active-high write enable.
- If the pin is held low during reset, then later driving it low turns write-enable and read-enable cycles into offset-register accesses.

The output port is modelled as a tri-state bus controlled by `oe_n`.

Top module: `prog_flag_fifo`

## Requirements
- R1: A synchronous reset (`rst` high on a clock edge of each domain) empties the buffer and gives `ef_n`=0, `pae_n`=0, `ff_n`=1 and `paf_n`=1. Both offsets return to DEPTH/8-1 (7 for DEPTH=64).
- R2: The level of `wen2_ld` during reset selects the mode: high selects enable mode and low selects load mode. In either mode, a word is written only on a `wclk` edge where `wen1_n`=0 and `wen2_ld`=1. In enable mode, `wen1_n`=0 with `wen2_ld`=0 does nothing.
- R3: In load mode, each `wclk` edge with `wen1_n`=0 and `wen2_ld`=0 stores `din` into the next offset slice, and does not write the buffer. The slices are taken cyclically in this order: empty-offset bits [8:0], empty-offset bits [17:9], full-offset bits [8:0], full-offset bits [17:9].
- R4: In load mode, each `rclk` edge with `ren1_n`=0, `ren2_n`=0 and `wen2_ld`=0 loads the next offset slice into the output register, following the same cyclic order as R3. It does not pop the buffer.
- R5: A read happens on an `rclk` edge with `ren1_n`=0 and `ren2_n`=0 while not empty (and not a readback). It loads the oldest word into the output register. Words leave in the order they were written.
- R6: `ef_n` is low exactly when the synchronized count is zero. `ff_n` is low exactly when it equals DEPTH. After a write into an empty buffer, `ef_n` rises within five `rclk` cycles, and the first word can be read on the next `rclk` edge.
- R7: `paf_n` is low when unread words >= DEPTH - m, where m is the full-side offset. It is updated on `wclk` edges.
- R8: `pae_n` is low when unread words <= n, where n is the empty-side offset. It is updated on `rclk` edges.
- R9: A write while `ff_n`=0, or a read while `ef_n`=0, leaves the buffer contents, the pointers and the output register unchanged.
- R10: When `oe_n`=1, `dq` is high-impedance. When `oe_n`=0, `dq` drives the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous reset, active high, held across edges of both clocks |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Second write enable or offset-access select; role latched at reset |
| din | input | 9 | Write data and offset load data |
| ren1_n | input | 1 | Read enable one, active low |
| ren2_n | input | 1 | Read enable two, active low |
| oe_n | input | 1 | Output enable, active low |
| dq | output | 9 | Tri-state data output |
| ef_n | output | 1 | Empty flag, active low, read domain |
| ff_n | output | 1 | Full flag, active low, write domain |
| pae_n | output | 1 | Nearly-empty flag, active low, read domain |
| paf_n | output | 1 | Nearly-full flag, active low, write domain |

## Verification
Different internal faults show up at the ports at different points:

- A corrupted pointer or synchronizer shows up as a wrong flag level a few cycles after the buffer goes quiet. It can also show up as a word read out of order or duplicated on the very next read.
- A wrong offset-slice sequencer is visible at once during readback: the output register gives the wrong nine bits on the first edge that follows.
- A broken mode latch shows up in the first access after reset. Either a write that should land is ignored, or an offset access turns into a buffer write that raises `ef_n` a few read cycles later.

// File: rtl/pff_pkg.sv
package pff_pkg;
  localparam int DW      = 9;
  localparam int OFS_W   = 2 * DW;
  localparam int PTR_MAX = 16;

  typedef logic [PTR_MAX-1:0] ptr_t;

  typedef enum logic [1:0] {
    SEL_AE_LO = 2'd0,
    SEL_AE_HI = 2'd1,
    SEL_AF_LO = 2'd2,
    SEL_AF_HI = 2'd3
  } ofs_sel_e;

  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // words used plus full-side offset reaches capacity
  function automatic logic near_full(int used, int ofs, int depth);
    return (used + ofs) >= depth;
  endfunction

  // words used at or below empty-side offset
  function automatic logic near_empty(int used, int ofs);
    return used <= ofs;
  endfunction

  function automatic logic [DW-1:0] ofs_part(logic [OFS_W-1:0] ae,
                                             logic [OFS_W-1:0] af,
                                             ofs_sel_e s);
    case (s)
      SEL_AE_LO: return ae[DW-1:0];
      SEL_AE_HI: return ae[OFS_W-1:DW];
      SEL_AF_LO: return af[DW-1:0];
      default:   return af[OFS_W-1:DW];
    endcase
  endfunction
endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pff_wr_ctl.sv
module pff_wr_ctl
  import pff_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic             wclk,
  input  logic             rst,
  input  logic             wen1_n,
  input  logic             wen2_ld,
  input  logic [DW-1:0]    din,
  input  logic [PW-1:0]    rgray_s,
  output logic             wr_evt,
  output logic             ld_evt,
  output logic [PW-1:0]    wbin,
  output logic [PW-1:0]    wgray,
  output logic             ff_n,
  output logic             paf_n,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam logic [OFS_W-1:0] DEF_OFS = OFS_W'(DEPTH / 8 - 1);

  logic          ld_mode;
  ofs_sel_e      ld_step;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] wbin_nxt;
  logic [PW-1:0] used_nxt;

  assign rbin_s   = PW'(from_gray(PTR_MAX'(rgray_s)));
  assign wr_evt   = !wen1_n && wen2_ld && ff_n;
  assign ld_evt   = ld_mode && !wen1_n && !wen2_ld;
  assign wbin_nxt = wbin + PW'(wr_evt);
  assign used_nxt = wbin_nxt - rbin_s;

  always_ff @(posedge wclk) begin
    if (rst) begin
      ld_mode <= !wen2_ld;
      wbin    <= '0;
      wgray   <= '0;
      ff_n    <= 1'b1;
      paf_n   <= 1'b1;
      ld_step <= SEL_AE_LO;
      ae_ofs  <= DEF_OFS;
      af_ofs  <= DEF_OFS;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= PW'(to_gray(PTR_MAX'(wbin_nxt)));
      ff_n  <= (used_nxt != PW'(DEPTH));
      paf_n <= !near_full(32'(used_nxt), 32'(af_ofs), DEPTH);
      if (ld_evt) begin
        case (ld_step)
          SEL_AE_LO: ae_ofs[DW-1:0]    <= din;
          SEL_AE_HI: ae_ofs[OFS_W-1:DW] <= din;
          SEL_AF_LO: af_ofs[DW-1:0]    <= din;
          default:   af_ofs[OFS_W-1:DW] <= din;
        endcase
        ld_step <= ofs_sel_e'(ld_step + 2'd1);
      end
    end
  end
endmodule

// File: rtl/pff_rd_ctl.sv
module pff_rd_ctl
  import pff_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic             rclk,
  input  logic             rst,
  input  logic             ren1_n,
  input  logic             ren2_n,
  input  logic             wen2_ld,
  input  logic [PW-1:0]    wgray_s,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  input  logic [DW-1:0]    mem_q,
  output logic             rd_evt,
  output logic             rb_evt,
  output logic [PW-1:0]    rbin,
  output logic [PW-1:0]    rgray,
  output logic             ef_n,
  output logic             pae_n,
  output logic [DW-1:0]    q
);
  logic          ld_mode;
  ofs_sel_e      rb_step;
  logic          rd_req;
  logic          ofs_sel;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] rbin_nxt;
  logic [PW-1:0] used_nxt;

  assign wbin_s   = PW'(from_gray(PTR_MAX'(wgray_s)));
  assign rd_req   = !ren1_n && !ren2_n;
  assign ofs_sel  = ld_mode && !wen2_ld;
  assign rb_evt   = rd_req && ofs_sel;
  assign rd_evt   = rd_req && !ofs_sel && ef_n;
  assign rbin_nxt = rbin + PW'(rd_evt);
  assign used_nxt = wbin_s - rbin_nxt;

  always_ff @(posedge rclk) begin
    if (rst) begin
      ld_mode <= !wen2_ld;
      rbin    <= '0;
      rgray   <= '0;
      ef_n    <= 1'b0;
      pae_n   <= 1'b0;
      rb_step <= SEL_AE_LO;
      q       <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= PW'(to_gray(PTR_MAX'(rbin_nxt)));
      ef_n  <= (used_nxt != '0);
      pae_n <= !near_empty(32'(used_nxt), 32'(ae_ofs));
      if (rd_evt) begin
        q <= mem_q;
      end else if (rb_evt) begin
        q       <= ofs_part(ae_ofs, af_ofs, rb_step);
        rb_step <= ofs_sel_e'(rb_step + 2'd1);
      end
    end
  end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [DW-1:0] din,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dq,
  output logic          ef_n,
  output logic          ff_n,
  output logic          pae_n,
  output logic          paf_n
);
  logic             wr_evt, ld_evt, rd_evt, rb_evt;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic [DW-1:0]    mem_q, q_reg;
  logic [DW-1:0]    mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (wr_evt) mem[wr_ptr[AW-1:0]] <= din;
  end
  assign mem_q = mem[rd_ptr[AW-1:0]];

  pff_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst(rst), .wen1_n(wen1_n), .wen2_ld(wen2_ld), .din(din),
    .rgray_s(rgray_s), .wr_evt(wr_evt), .ld_evt(ld_evt), .wbin(wr_ptr),
    .wgray(wgray), .ff_n(ff_n), .paf_n(paf_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  pff_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst(rst), .ren1_n(ren1_n), .ren2_n(ren2_n), .wen2_ld(wen2_ld),
    .wgray_s(wgray_s), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .mem_q(mem_q),
    .rd_evt(rd_evt), .rb_evt(rb_evt), .rbin(rd_ptr), .rgray(rgray),
    .ef_n(ef_n), .pae_n(pae_n), .q(q_reg)
  );

  pff_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
  pff_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

  assign dq = oe_n ? {DW{1'bz}} : q_reg;
endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
  parameter int PW = 7
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          ef_n,
  input logic          ff_n,
  input logic          pae_n,
  input logic          paf_n,
  input logic          wr_evt,
  input logic          ld_evt,
  input logic          rd_evt,
  input logic          rb_evt,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr
);
  // R9
  wr_when_full_chk: assert property (@(posedge wclk) disable iff (rst)
    !ff_n |=> $stable(wr_ptr));
  // R9
  rd_when_empty_chk: assert property (@(posedge rclk) disable iff (rst)
    !ef_n |=> $stable(rd_ptr));
  // R3
  load_no_push_chk: assert property (@(posedge wclk) disable iff (rst)
    ld_evt |=> $stable(wr_ptr));
  // R4
  readback_no_pop_chk: assert property (@(posedge rclk) disable iff (rst)
    rb_evt |=> $stable(rd_ptr));
  // R7
  full_has_af_chk: assert property (@(posedge wclk) disable iff (rst)
    !ff_n |-> !paf_n);
  // R8
  empty_has_ae_chk: assert property (@(posedge rclk) disable iff (rst)
    !ef_n |-> !pae_n);
  // R5
  push_step_chk: assert property (@(posedge wclk) disable iff (rst)
    wr_evt |=> wr_ptr == $past(wr_ptr) + PW'(1));
  // R5
  pop_step_chk: assert property (@(posedge rclk) disable iff (rst)
    rd_evt |=> rd_ptr == $past(rd_ptr) + PW'(1));
endmodule

bind prog_flag_fifo pff_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .ef_n(ef_n), .ff_n(ff_n),
  .pae_n(pae_n), .paf_n(paf_n), .wr_evt(wr_evt), .ld_evt(ld_evt),
  .rd_evt(rd_evt), .rb_evt(rb_evt), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/prog_flag_fifo_bench.sv
`timescale 1ns/1ps
module prog_flag_fifo_bench;
  localparam int DEPTH = 64;

  logic       wclk = 0, rclk = 0, rst = 1;
  logic       wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 0;
  logic [8:0] din = '0;
  wire  [8:0] dq;
  wire        ef_n, ff_n, pae_n, paf_n;

  int checks = 0, errors = 0;
  int ofs_n = DEPTH / 8 - 1, ofs_m = DEPTH / 8 - 1;
  logic [8:0] mq[$];
  logic [8:0] last_q;
  bit done = 0;

  always #5 wclk = ~wclk;
  always #8 rclk = ~rclk;

  prog_flag_fifo #(.DEPTH(DEPTH)) u_prog_flag_fifo (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .dq(dq),
    .ef_n(ef_n), .ff_n(ff_n), .pae_n(pae_n), .paf_n(paf_n)
  );

  function automatic int exp_pae(int used, int n);
    return (used > n) ? 1 : 0;
  endfunction
  function automatic int exp_paf(int used, int m);
    return (DEPTH - used > m) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    rst = 1; wen2_ld = pin; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    repeat (6) @(negedge wclk);
    rst = 0;
    mq.delete();
    ofs_n = DEPTH / 8 - 1; ofs_m = DEPTH / 8 - 1;
    last_q = '0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (3) @(negedge wclk);
  endtask

  task automatic check_flags(input string tag);
    int used = mq.size();
    check({tag, " R6 ef_n"}, int'(ef_n), used != 0 ? 1 : 0);
    check({tag, " R6 ff_n"}, int'(ff_n), used != DEPTH ? 1 : 0);
    check({tag, " R8 pae_n"}, int'(pae_n), exp_pae(used, ofs_n));
    check({tag, " R7 paf_n"}, int'(paf_n), exp_paf(used, ofs_m));
  endtask

  task automatic push(input logic [8:0] d);
    @(negedge wclk); din = d; wen1_n = 0;
    @(negedge wclk); wen1_n = 1;
    if (mq.size() < DEPTH) mq.push_back(d);
  endtask

  task automatic pop(input string tag);
    @(negedge rclk); ren1_n = 0; ren2_n = 0;
    @(negedge rclk); ren1_n = 1; ren2_n = 1;
    if (mq.size() > 0) last_q = mq.pop_front();
    check({tag, " R5 data"}, int'(dq), int'(last_q));
  endtask

  initial begin
    #3ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1 reset state in enable mode
    do_reset(1'b1);
    settle();
    check_flags("R1 reset");
    // R10 output high impedance
    oe_n = 1; #1;
    check("R10 hiz", (dq === 9'bz) ? 1 : 0, 1);
    oe_n = 0; #1;
    check("R10 drive", int'(dq), 0);
    // R2 enable mode: wen1 alone writes nothing
    @(negedge wclk); wen2_ld = 0; wen1_n = 0; din = 9'h1AA;
    @(negedge wclk); wen1_n = 1; wen2_ld = 1;
    settle();
    check("R2 no write", int'(ef_n), 0);
    // R6 first word latency then R5 data
    push(9'h155);
    begin
      int waited = 0;
      while (!ef_n && waited < 12) begin @(negedge rclk); waited++; end
      check("R6 ef latency ok", (waited >= 1 && waited <= 5) ? 1 : 0, 1);
    end
    pop("first");
    // R9 read while empty keeps output register
    settle();
    pop("R9 empty read");
    check("R9 ef stays", int'(ef_n), 0);
    // random bursts
    for (int r = 0; r < 16; r++) begin
      int nw = $urandom_range(0, 24);
      int nr = $urandom_range(0, 24);
      for (int i = 0; i < nw; i++) push(9'($urandom_range(0, 511)));
      settle();
      check_flags("rand wr");
      for (int i = 0; i < nr; i++) pop("rand");
      settle();
      check_flags("rand rd");
    end
    // fill past full: R9 extra writes dropped
    while (mq.size() < DEPTH) push(9'($urandom_range(0, 511)));
    push(9'h0F0); push(9'h0F1);
    settle();
    check_flags("R9 full");
    while (mq.size() > 0) pop("drain");
    settle();
    check_flags("R9 drained");

    // R3 R4 load mode
    do_reset(1'b0);
    settle();
    check_flags("R1 load-mode reset");
    @(negedge wclk); wen2_ld = 0; wen1_n = 0; din = 9'd5;
    @(negedge wclk); din = 9'd0;
    @(negedge wclk); din = 9'd10;
    @(negedge wclk); din = 9'd0;
    @(negedge wclk); wen1_n = 1;
    ofs_n = 5; ofs_m = 10;
    settle();
    check("R3 no buffer write", int'(ef_n), 0);
    @(negedge rclk); ren1_n = 0; ren2_n = 0;
    @(negedge rclk); check("R4 slice ae lo", int'(dq), 5);
    @(negedge rclk); check("R4 slice ae hi", int'(dq), 0);
    @(negedge rclk); check("R4 slice af lo", int'(dq), 10);
    @(negedge rclk); check("R4 slice af hi", int'(dq), 0);
    @(negedge rclk); check("R4 wrap ae lo", int'(dq), 5);
    ren1_n = 1; ren2_n = 1; wen2_ld = 1;
    settle();
    check("R4 no pop", int'(ef_n), 0);
    // R8 threshold n=5 and R7 threshold m=10
    for (int i = 0; i < 5; i++) push(9'(i + 100));
    settle(); check_flags("R8 at n");
    push(9'd200);
    settle(); check_flags("R8 above n");
    while (mq.size() < DEPTH - 11) push(9'($urandom_range(0, 511)));
    settle(); check_flags("R7 below");
    push(9'd301);
    settle(); check_flags("R7 at");
    pop("R5 load-mode read");
    settle(); check_flags("R7 after read");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule